// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

This block is an 8-bit up-counter that advances either once per instruction cycle (one `clk` period) or on a chosen edge of an external input pin. The pin is passed through a two-flop synchronizer before edge detection. A single 8-bit prescaler is shared with a watchdog. A control bit hands the prescaler to exactly one user. When the counter owns it, the counter advances once per 2^(N+1) source events. When the watchdog owns it, the watchdog oscillator tick is divided by 2^N and the counter sees every source event directly.

Software loads the counter through a write port and reads it back at any time. After a load, the counter holds for two cycles. A load also clears the prescaler when the counter owns it. The counter wraps from FFh to 00h, and that wrap sets a sticky interrupt flag. The interrupt output is that flag gated by an enable input. A sleep input freezes counting; the watchdog path keeps running while sleep is high.

Top module: `spt_timer`

## Requirements
- R1: After a synchronous reset the counter reads 00h, the interrupt flag and interrupt output are 0, and the control register reads 6'b111111.
- R2: Control bit layout: bit 5 selects the source (0 = every clock, 1 = external pin edges), bit 4 selects the pin edge (0 = rising, 1 = falling), bit 3 assigns the prescaler (0 = counter, 1 = watchdog), bits 2:0 hold the ratio code N. A control write takes effect at the next edge and reads back unchanged.
- R3: With bit 3 = 1 and bit 5 = 0, the counter increments on every clock edge.
- R4: With bit 3 = 0, the counter increments once every 2^(N+1) source events, so the ratio runs from 1:2 to 1:256.
- R5: In external mode, when a qualifying pin transition is present before edge k, the counter (with bit 3 = 1) increments at edge k+2.
- R6: A counter write loads the written value at the next edge. The two edges that follow never increment the counter, and counting resumes at the third.
- R7: A counter write while bit 3 = 0 resets the prescaler count. The ratio setting is kept, so the next increment comes a full 2^(N+1) events after the write.
- R8: A wrap from FFh to 00h sets the flag. The flag stays set until `flag_clr`, and a wrap in the same cycle as `flag_clr` leaves it set.
- R9: `irq` is registered. It is high in the cycle after an edge at which both the updated flag and `irq_en` are 1, and low otherwise.
- R10: `wdt_tick` is registered. With bit 3 = 1 it pulses once per 2^N oscillator ticks. With bit 3 = 0 it repeats each oscillator tick one cycle later.
- R11: While `sleep` is high the counter does not increment. Source events that arrive during sleep are discarded, and a prescaler owned by the counter does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Asynchronous external count input |
| sleep | input | 1 | Halts counting while high |
| osc_tick | input | 1 | Watchdog oscillator tick, one clock wide |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write value |
| cnt_rdata | output | 8 | Current counter value |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 6 | Control write value |
| ctl_rdata | output | 6 | Control register value |
| irq_en | input | 1 | Interrupt mask (1 = enabled) |
| flag_clr | input | 1 | Clears the overflow flag |
| irq_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Masked interrupt output |
| wdt_tick | output | 1 | Divided tick to the watchdog |

## Verification
The hardest case to reach is the prescaler clear in R7. It is only visible at the 1:256 ratio, where an increment would come early if a stale prescaler count survived the write. The bench lets the prescaler run for 100 cycles, loads the counter, and shows that no increment occurs until exactly 256 cycles later. A second hard case is a wrap that coincides with `flag_clr`. To produce it, the bench loads FFh, waits out the two hold cycles, and raises the clear on the wrapping edge. A long randomized phase then mixes control writes, sleep, pin toggles and oscillator ticks, and a reference model checks the outputs on every clock.

// File: rtl/spt_pkg.sv
package spt_pkg;
  localparam int RATIO_W = 3;
  localparam int PRE_W   = 1 << RATIO_W;
  localparam int CTL_W   = RATIO_W + 3;

  typedef struct packed {
    logic               ext_src;   // 1: pin edges, 0: every clock
    logic               fall_edge; // 1: falling, 0: rising
    logic               to_wdt;    // 1: prescaler serves watchdog
    logic [RATIO_W-1:0] ratio;
  } ctl_t;
endpackage

// File: rtl/spt_edge_sync.sv
module spt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_hit
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], pin};
  end

  logic lvl, lvl_d;
  assign lvl   = sh[STAGES-1];
  assign lvl_d = sh[STAGES];

  always_comb begin
    if (fall_sel) edge_hit = lvl_d & ~lvl;
    else          edge_hit = lvl & ~lvl_d;
  end
endmodule

// File: rtl/spt_prescaler.sv
module spt_prescaler #(
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          src_tick,
  input  logic          osc_tick,
  input  logic          to_wdt,
  input  logic [RW-1:0] ratio,
  input  logic          clear,
  output logic          cnt_tick,
  output logic          wdt_pulse
);
  localparam int PW = 1 << RW;

  logic [PW-1:0] pre;
  logic [PW:0]   carry;   // carry[i]: low i bits of pre all ones
  logic [RW:0]   lo_sel, hi_sel;
  logic          step;

  assign carry[0] = 1'b1;
  for (genvar i = 0; i < PW; i++) begin : g_carry
    assign carry[i+1] = carry[i] & pre[i];
  end

  assign lo_sel = {1'b0, ratio};
  assign hi_sel = lo_sel + (RW+1)'(1);
  assign step   = to_wdt ? osc_tick : src_tick;

  always_ff @(posedge clk) begin
    if (rst || clear) pre <= '0;
    else if (step)    pre <= pre + PW'(1);
  end

  always_comb begin
    if (to_wdt) begin
      cnt_tick  = src_tick;
      wdt_pulse = osc_tick & carry[lo_sel];
    end else begin
      cnt_tick  = src_tick & carry[hi_sel];
      wdt_pulse = osc_tick;
    end
  end
endmodule

// File: rtl/spt_count_core.sv
module spt_count_core #(
  parameter int W    = 8,
  parameter int HOLD = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         flag_clr,
  input  logic         irq_en,
  output logic [W-1:0] cnt_q,
  output logic         flag_q,
  output logic         irq_q
);
  localparam int HW = $clog2(HOLD + 1);

  logic [HW-1:0] hold;
  logic          allow, wrap, flag_nx;

  assign allow   = inc && (hold == '0) && !we;
  assign wrap    = allow && (&cnt_q);
  assign flag_nx = wrap | (flag_q & ~flag_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hold   <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (we) begin
        cnt_q <= wdata;
        hold  <= HW'(HOLD);
      end else begin
        if (hold != '0) hold  <= hold - HW'(1);
        if (allow)      cnt_q <= cnt_q + W'(1);
      end
      flag_q <= flag_nx;
      irq_q  <= flag_nx & irq_en;
    end
  end
endmodule

// File: rtl/spt_timer.sv
module spt_timer
  import spt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int WR_HOLD     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_pin,
  input  logic             sleep,
  input  logic             osc_tick,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_rdata,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic             irq_flag,
  output logic             irq,
  output logic             wdt_tick
);
  ctl_t ctl;
  logic pin_edge, src_tick, cnt_tick, wdt_pulse, pre_clr;

  always_ff @(posedge clk) begin
    if (rst)         ctl <= '1;
    else if (ctl_we) ctl <= ctl_t'(ctl_wdata);
  end
  assign ctl_rdata = ctl;

  spt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(ext_pin),
    .fall_sel(ctl.fall_edge), .edge_hit(pin_edge)
  );

  assign src_tick = ~sleep & (ctl.ext_src ? pin_edge : 1'b1);
  assign pre_clr  = cnt_we & ~ctl.to_wdt;

  spt_prescaler #(.RW(RATIO_W)) u_pre (
    .clk(clk), .rst(rst), .src_tick(src_tick), .osc_tick(osc_tick),
    .to_wdt(ctl.to_wdt), .ratio(ctl.ratio), .clear(pre_clr),
    .cnt_tick(cnt_tick), .wdt_pulse(wdt_pulse)
  );

  spt_count_core #(.W(CNT_W), .HOLD(WR_HOLD)) u_core (
    .clk(clk), .rst(rst), .inc(cnt_tick), .we(cnt_we), .wdata(cnt_wdata),
    .flag_clr(flag_clr), .irq_en(irq_en),
    .cnt_q(cnt_rdata), .flag_q(irq_flag), .irq_q(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) wdt_tick <= 1'b0;
    else     wdt_tick <= wdt_pulse;
  end
endmodule

// File: rtl/spt_timer_chk.sv
module spt_timer_chk #(
  parameter int W  = 8,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          sleep,
  input logic          cnt_we,
  input logic [W-1:0]  cnt_wdata,
  input logic [W-1:0]  cnt_rdata,
  input logic [CW-1:0] ctl_rdata,
  input logic          irq_en,
  input logic          flag_clr,
  input logic          irq_flag,
  input logic          irq
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (ctl_rdata == '1 && cnt_rdata == '0 && !irq_flag && !irq));

  // R6
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> cnt_rdata == $past(cnt_wdata));

  // R6
  write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt_we) && !cnt_we) |=> $stable(cnt_rdata));

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_we |=> (cnt_rdata == $past(cnt_rdata) || cnt_rdata == $past(cnt_rdata) + W'(1)));

  // R11
  sleep_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep && !cnt_we) |=> $stable(cnt_rdata));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !flag_clr) |=> irq_flag);

  // R8
  flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> ((&$past(cnt_rdata)) && cnt_rdata == '0));

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);
endmodule

bind spt_timer spt_timer_chk #(.W(CNT_W), .CW(spt_pkg::CTL_W)) u_chk (
  .clk(clk), .rst(rst), .sleep(sleep), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
  .cnt_rdata(cnt_rdata), .ctl_rdata(ctl_rdata), .irq_en(irq_en),
  .flag_clr(flag_clr), .irq_flag(irq_flag), .irq(irq)
);

// File: tb/tb_spt_timer.sv
`timescale 1ns/1ps
module tb_spt_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_pin = 1'b0, sleep = 1'b0, osc_tick = 1'b0;
  logic       cnt_we = 1'b0, ctl_we = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
  logic [7:0] cnt_wdata = 8'h00;
  logic [5:0] ctl_wdata = 6'h00;
  logic [7:0] cnt_rdata;
  logic [5:0] ctl_rdata;
  logic       irq_flag, irq, wdt_tick;

  always #4 clk = ~clk;

  spt_timer dut (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .sleep(sleep), .osc_tick(osc_tick),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .irq_en(irq_en), .flag_clr(flag_clr), .irq_flag(irq_flag), .irq(irq),
    .wdt_tick(wdt_tick)
  );

  int total = 0, bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_cnt, m_flag, m_irq, m_wdt, m_ctl, m_pre, m_hold;
  int pq[$];

  task automatic model_step();
    int n, ext, fall, own_wdt, lvl, lvl_d, ev, src, inc, fire, wrap;
    if (rst) begin
      m_cnt = 0; m_flag = 0; m_irq = 0; m_wdt = 0; m_ctl = 63; m_pre = 0; m_hold = 0;
      pq = '{0, 0, 0};
      return;
    end
    n = m_ctl & 7; own_wdt = (m_ctl >> 3) & 1;
    fall = (m_ctl >> 4) & 1; ext = (m_ctl >> 5) & 1;
    lvl = pq[1]; lvl_d = pq[0];
    ev = fall ? (lvl_d == 1 && lvl == 0) : (lvl == 1 && lvl_d == 0);
    pq.push_back(int'(ext_pin)); void'(pq.pop_front());
    src = sleep ? 0 : (ext ? ev : 1);
    inc = 0; fire = 0;
    if (!own_wdt) begin
      if (src != 0) begin
        m_pre = (m_pre + 1) % 256;
        inc = (m_pre % (2 << n)) == 0;
      end
      fire = osc_tick;
      if (cnt_we) m_pre = 0;
    end else begin
      inc = src;
      if (osc_tick) begin
        fire = (m_pre % (1 << n)) == ((1 << n) - 1);
        m_pre = (m_pre + 1) % 256;
      end
    end
    wrap = 0;
    if (cnt_we) begin
      m_cnt = cnt_wdata; m_hold = 2;
    end else begin
      if (inc != 0 && m_hold == 0) begin
        if (m_cnt == 255) wrap = 1;
        m_cnt = (m_cnt + 1) % 256;
      end
      if (m_hold > 0) m_hold--;
    end
    m_flag = (wrap != 0 || (m_flag != 0 && !flag_clr)) ? 1 : 0;
    m_irq  = (m_flag != 0 && irq_en) ? 1 : 0;
    m_wdt  = fire;
    if (ctl_we) m_ctl = ctl_wdata;
  endtask

  always @(posedge clk) model_step();

  task automatic chk(string req, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    total++;
    if (cnt_rdata != m_cnt[7:0] || irq_flag != m_flag[0] || irq != m_irq[0] ||
        wdt_tick != m_wdt[0] || ctl_rdata != m_ctl[5:0]) begin
      bad++;
      $display("FAIL %s model mismatch actual cnt=%0d flag=%0d irq=%0d wdt=%0d ctl=%0d expected cnt=%0d flag=%0d irq=%0d wdt=%0d ctl=%0d at %0t",
               cur_req, cnt_rdata, irq_flag, irq, wdt_tick, ctl_rdata,
               m_cnt, m_flag, m_irq, m_wdt, m_ctl, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(int n);
    repeat (n) cyc();
  endtask

  task automatic wr_ctl(logic [5:0] v);
    ctl_we = 1'b1; ctl_wdata = v; cyc(); ctl_we = 1'b0;
  endtask

  task automatic wr_cnt(logic [7:0] v);
    cnt_we = 1'b1; cnt_wdata = v; cyc(); cnt_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    int held, pulses;
    run(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    chk("R1", cnt_rdata, 0, "cnt");
    chk("R1", ctl_rdata, 63, "ctl");
    chk("R1", irq_flag, 0, "flag");
    chk("R1", irq, 0, "irq");

    // R2 / R3: direct internal counting and write hold
    cur_req = "R3";
    wr_ctl(6'b001000);
    chk("R2", ctl_rdata, 8, "ctl readback");
    wr_cnt(8'h10);
    run(10);
    chk("R6", cnt_rdata, 8'h18, "hold then step");
    run(10);
    chk("R3", cnt_rdata, 8'h22, "every clock");

    // R8 / R9: wrap, sticky flag, clear
    cur_req = "R8";
    irq_en = 1'b1;
    wr_cnt(8'hFC);
    run(6);
    chk("R8", cnt_rdata, 0, "wrap value");
    chk("R8", irq_flag, 1, "flag set");
    chk("R9", irq, 1, "irq enabled");
    run(3);
    chk("R8", irq_flag, 1, "flag sticky");
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
    chk("R8", irq_flag, 0, "flag cleared");
    wr_cnt(8'hFF);
    run(2);
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
    chk("R8", irq_flag, 1, "wrap beats clear");
    irq_en = 1'b0; cyc();
    chk("R9", irq, 0, "irq masked");
    chk("R9", irq_flag, 1, "flag under mask");
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;

    // R4: prescaler owned by counter
    cur_req = "R4";
    wr_ctl(6'b000001);
    wr_cnt(8'h00);
    run(40);
    chk("R4", cnt_rdata, 10, "ratio 1:4");
    for (int r = 0; r < 4; r++) begin
      wr_ctl(6'(r));
      wr_cnt(8'h00);
      run(60);
    end

    // R7: write clears prescaler at 1:256
    cur_req = "R7";
    wr_ctl(6'b000111);
    run(100);
    wr_cnt(8'h00);
    run(255);
    chk("R7", cnt_rdata, 0, "no early step");
    cyc();
    chk("R7", cnt_rdata, 1, "step after 256");

    // R5: external pin, two-cycle synchronizer latency
    cur_req = "R5";
    wr_ctl(6'b101000);
    wr_cnt(8'h00);
    run(5);
    ext_pin = 1'b1;
    cyc(); chk("R5", cnt_rdata, 0, "rise k");
    cyc(); chk("R5", cnt_rdata, 0, "rise k+1");
    cyc(); chk("R5", cnt_rdata, 1, "rise k+2");
    wr_ctl(6'b111000);
    ext_pin = 1'b0;
    cyc(); chk("R5", cnt_rdata, 1, "fall k");
    cyc(); chk("R5", cnt_rdata, 1, "fall k+1");
    cyc(); chk("R5", cnt_rdata, 2, "fall k+2");
    for (int m = 0; m < 3; m++) begin
      wr_ctl(m == 0 ? 6'b101000 : (m == 1 ? 6'b111000 : 6'b100000));
      for (int t = 0; t < 60; t++) begin
        ext_pin = ((t / 3) % 2) != 0;
        cyc();
      end
    end

    // R11: sleep freezes counting
    cur_req = "R11";
    wr_ctl(6'b001000);
    run(4);
    sleep = 1'b1;
    cyc();
    held = cnt_rdata;
    run(20);
    chk("R11", cnt_rdata, held, "internal during sleep");
    wr_ctl(6'b101000);
    for (int t = 0; t < 20; t++) begin
      ext_pin = ((t / 2) % 2) != 0;
      cyc();
    end
    chk("R11", cnt_rdata, held, "pin during sleep");
    ext_pin = 1'b0;
    sleep = 1'b0;
    run(5);

    // R10: watchdog tick
    cur_req = "R10";
    wr_ctl(6'b001010);
    osc_tick = 1'b1;
    pulses = 0;
    for (int t = 0; t < 32; t++) begin
      cyc();
      if (wdt_tick) pulses++;
    end
    chk("R10", pulses, 8, "1:4 pulse count");
    osc_tick = 1'b0;
    wr_ctl(6'b000000);
    osc_tick = 1'b1; cyc(); osc_tick = 1'b0;
    chk("R10", wdt_tick, 1, "bypass tick");
    cyc();
    chk("R10", wdt_tick, 0, "bypass idle");
    for (int r = 0; r < 8; r++) begin
      wr_ctl(6'b001000 | 6'(r));
      for (int t = 0; t < 40; t++) begin
        osc_tick = (t % 3) == 0;
        cyc();
      end
    end
    osc_tick = 1'b0;

    // R2: randomized mix against the model
    cur_req = "R2";
    for (int t = 0; t < 4000; t++) begin
      ext_pin   = ($urandom % 4 == 0) ? ~ext_pin : ext_pin;
      sleep     = ($urandom % 20) == 0;
      osc_tick  = ($urandom % 2) == 0;
      irq_en    = ($urandom % 3) != 0;
      flag_clr  = ($urandom % 16) == 0;
      cnt_we    = ($urandom % 40) == 0;
      cnt_wdata = 8'($urandom);
      ctl_we    = ($urandom % 150) == 0;
      ctl_wdata = 6'($urandom);
      cyc();
    end
    cnt_we = 1'b0; ctl_we = 1'b0; flag_clr = 1'b0;
    run(4);
    finish_run();
  end
endmodule